// File: doc/BRIEF.md
# Dual-View Interrupt Status Register

This block holds the 32-bit interrupt status word of a network MAC. A slave port in the style of the AHB-Lite bus reaches it at two word offsets that share one storage. The preserve view returns the word and leaves it unchanged. A write of 1s to the preserve view clears those bits. The clearing view is read-only. A read there returns the word and then clears the bits in the byte lanes the transfer covers, so a handler that services everything it reads needs no separate write.

MAC event pulses set status bits, one pulse input per bit. A separate enable word is ANDed with the status, and any surviving bit raises the single interrupt output. The port has no wait states. A read returns data in its data phase, and both kinds of clear take effect on the clock edge that ends the data phase. When an event and a clear hit the same bit in the same cycle, the event wins.

Top module: `intr_status_dual`

## Requirements
- R1: After reset every status bit is 0 and `irq_o` is low.
- R2: A 1 on `event_i[i]` sets status bit i on the next clock edge. The bit then stays set until a clear reaches it.
- R3: A read at the preserve offset (0x28) and a read at the clearing offset (0x2C) return the same stored word on `hrdata_o` during the data phase.
- R4: A read at the preserve offset leaves every status bit unchanged.
- R5: A write to the preserve offset clears each status bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R6: A read at the clearing offset returns the word as it was before the clear, then clears only the lanes the read selects. Lane k covers bits 8k+7 to 8k, and the encoding is little-endian. A byte read (`hsize_i`=0) clears lane `haddr_i[1:0]`. A halfword read (`hsize_i`=1) clears lanes 1:0 when `haddr_i[1]` is 0 and lanes 3:2 when it is 1. A word read (`hsize_i`=2) clears all four lanes.
- R7: A write to the clearing offset changes no status bit.
- R8: If an event pulse and a clear (either kind) reach the same bit in the same cycle, the bit ends up set.
- R9: Bit 31 is reserved. It always reads 0 and no event can set it. Bit 30 is the remote wake-up status.
- R10: `irq_o` is high exactly when some status bit and the matching bit of `int_en_i` are both 1.
- R11: A transfer to any other offset changes no status bit, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsel_i | input | 1 | Slave select |
| haddr_i | input | ADDR_W | Byte address within the register block |
| htrans_i | input | 2 | Transfer type; bit 1 high marks an active transfer |
| hwrite_i | input | 1 | 1 = write, 0 = read |
| hsize_i | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| hready_i | input | 1 | Bus ready; an address phase counts only when it is high |
| hwdata_i | input | 32 | Write data, sampled in the data phase |
| hrdata_o | output | 32 | Read data, valid in the data phase |
| event_i | input | 32 | Per-bit MAC event pulses |
| int_en_i | input | 32 | Interrupt enable word |
| irq_o | output | 1 | Interrupt request |

## Verification
Directed reads at the clearing offset try every byte address with a byte transfer, both halfword positions and a full word. Each follow-up preserve read then shows which lanes were cleared, which tells a correct lane decode apart from a shifted or inverted one. Events are also injected in the same data phase as a write-1 clear or a read-clear. This separates a design where the set wins from one where the clear wins. Random traffic mixes the views, sizes, offsets, event words and enable words. Each read is compared with the bench's model, which tells the preserve view apart from the clearing view and catches any leak from the write-only or unmapped paths.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    VIEW_NONE = 2'd0,
    VIEW_PRES = 2'd1,
    VIEW_CLR  = 2'd2
  } view_e;

  // byte lanes touched by a transfer of the given size at the given low address
  function automatic logic [LANES-1:0] lane_sel(input logic [2:0] sz, input logic [1:0] lo);
    logic [LANES-1:0] m;
    case (sz)
      3'd0:    m = LANES'(1) << lo;
      3'd1:    m = lo[1] ? 4'b1100 : 4'b0011;
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/isr_bus_decode.sv
module isr_bus_decode
  import isr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] PRES_OFS = 'h028,
  parameter logic [ADDR_W-1:0] CLR_OFS  = 'h02C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsel_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [2:0]        hsize_i,
  input  logic              hready_i,
  output logic              wr1c_en,
  output logic              rdclr_en,
  output logic              rd_en,
  output logic [DATA_W-1:0] clr_lanes
);
  localparam int WA = ADDR_W - 2;

  logic             dp_valid;
  logic             dp_write;
  view_e            dp_view;
  logic [LANES-1:0] dp_lanes;
  view_e            ap_view;

  always_comb begin
    if (haddr_i[ADDR_W-1:2] == PRES_OFS[ADDR_W-1:2])     ap_view = VIEW_PRES;
    else if (haddr_i[ADDR_W-1:2] == CLR_OFS[ADDR_W-1:2]) ap_view = VIEW_CLR;
    else                                                 ap_view = VIEW_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_valid <= 1'b0;
      dp_write <= 1'b0;
      dp_view  <= VIEW_NONE;
      dp_lanes <= '0;
    end else if (hready_i) begin
      dp_valid <= hsel_i & htrans_i[1];
      dp_write <= hwrite_i;
      dp_view  <= ap_view;
      dp_lanes <= lane_sel(hsize_i, haddr_i[1:0]);
    end
  end

  assign wr1c_en  = dp_valid &  dp_write & (dp_view == VIEW_PRES);
  assign rdclr_en = dp_valid & ~dp_write & (dp_view == VIEW_CLR);
  assign rd_en    = dp_valid & ~dp_write & (dp_view != VIEW_NONE);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign clr_lanes[8*k +: 8] = {8{dp_lanes[k]}};
  end

  logic unused_w;
  assign unused_w = ^{WA};
endmodule

// File: rtl/isr_status_bits.sv
module isr_status_bits
  import isr_pkg::*;
#(
  parameter logic [DATA_W-1:0] RSVD_MASK = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] event_i,
  input  logic              wr1c_en,
  input  logic [DATA_W-1:0] wr1c_data,
  input  logic              rdclr_en,
  input  logic [DATA_W-1:0] clr_lanes,
  output logic [DATA_W-1:0] status_q
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (RSVD_MASK[i]) begin : g_rsvd
      assign status_q[i] = 1'b0;
      logic unused_b;
      assign unused_b = event_i[i] ^ wr1c_data[i] ^ clr_lanes[i];
    end else begin : g_live
      logic clr;
      logic st;
      assign clr = (wr1c_en & wr1c_data[i]) | (rdclr_en & clr_lanes[i]);
      always_ff @(posedge clk) begin
        if (rst) st <= 1'b0;
        else     st <= event_i[i] | (st & ~clr);
      end
      assign status_q[i] = st;
    end
  end
endmodule

// File: rtl/intr_status_dual.sv
module intr_status_dual
  import isr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] PRES_OFS = 'h028,
  parameter logic [ADDR_W-1:0] CLR_OFS  = 'h02C,
  parameter logic [DATA_W-1:0] RSVD_MASK = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsel_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [2:0]        hsize_i,
  input  logic              hready_i,
  input  logic [31:0]       hwdata_i,
  output logic [31:0]       hrdata_o,
  input  logic [31:0]       event_i,
  input  logic [31:0]       int_en_i,
  output logic              irq_o
);
  logic              wr1c_en;
  logic              rdclr_en;
  logic              rd_en;
  logic [DATA_W-1:0] clr_lanes;
  logic [DATA_W-1:0] status_q;

  isr_bus_decode #(
    .ADDR_W(ADDR_W), .PRES_OFS(PRES_OFS), .CLR_OFS(CLR_OFS)
  ) u_dec (
    .clk(clk), .rst(rst), .hsel_i(hsel_i), .haddr_i(haddr_i),
    .htrans_i(htrans_i), .hwrite_i(hwrite_i), .hsize_i(hsize_i),
    .hready_i(hready_i), .wr1c_en(wr1c_en), .rdclr_en(rdclr_en),
    .rd_en(rd_en), .clr_lanes(clr_lanes)
  );

  isr_status_bits #(.RSVD_MASK(RSVD_MASK)) u_bits (
    .clk(clk), .rst(rst), .event_i(event_i),
    .wr1c_en(wr1c_en), .wr1c_data(hwdata_i),
    .rdclr_en(rdclr_en), .clr_lanes(clr_lanes),
    .status_q(status_q)
  );

  // read data comes straight from the status flops in the data phase
  assign hrdata_o = rd_en ? status_q : '0;
  assign irq_o    = |(status_q & int_en_i);
endmodule

// File: rtl/intr_status_dual_chk.sv
module intr_status_dual_chk #(
  parameter logic [31:0] RSVD_MASK = 32'h8000_0000
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] event_i,
  input logic [31:0] int_en_i,
  input logic        irq_o,
  input logic [31:0] status_q,
  input logic        wr1c_en,
  input logic        rdclr_en
);
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (status_q == 32'h0));

  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    (!wr1c_en && !rdclr_en) |=> ((status_q & $past(status_q)) == $past(status_q)));

  a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
    (|(event_i & ~RSVD_MASK)) |=>
      ((status_q & $past(event_i & ~RSVD_MASK)) == $past(event_i & ~RSVD_MASK)));

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (status_q & RSVD_MASK) == 32'h0);

  a_r10_no_enable_no_irq: assert property (@(posedge clk) disable iff (rst)
    (int_en_i == 32'h0) |-> !irq_o);

  a_r7_one_clear_path: assert property (@(posedge clk) disable iff (rst)
    !(wr1c_en && rdclr_en));
endmodule

bind intr_status_dual intr_status_dual_chk #(.RSVD_MASK(RSVD_MASK)) u_chk (
  .clk(clk), .rst(rst), .event_i(event_i), .int_en_i(int_en_i),
  .irq_o(irq_o), .status_q(status_q), .wr1c_en(wr1c_en), .rdclr_en(rdclr_en)
);

// File: tb/intr_status_dual_bench.sv
module intr_status_dual_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] PRES = 12'h028;
  localparam logic [11:0] CLRV = 12'h02C;
  localparam logic [11:0] OTHER = 12'h030;
  localparam logic [31:0] RSVD = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsel_i = 1'b0;
  logic [11:0] haddr_i = '0;
  logic [1:0]  htrans_i = 2'b00;
  logic        hwrite_i = 1'b0;
  logic [2:0]  hsize_i = 3'd2;
  logic        hready_i = 1'b1;
  logic [31:0] hwdata_i = '0;
  logic [31:0] hrdata_o;
  logic [31:0] event_i = '0;
  logic [31:0] int_en_i = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_st = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_status_dual u_intr_status_dual (
    .clk(clk), .rst(rst), .hsel_i(hsel_i), .haddr_i(haddr_i),
    .htrans_i(htrans_i), .hwrite_i(hwrite_i), .hsize_i(hsize_i),
    .hready_i(hready_i), .hwdata_i(hwdata_i), .hrdata_o(hrdata_o),
    .event_i(event_i), .int_en_i(int_en_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // cleared bit range of a read at the clearing offset, built from bit indices
  function automatic logic [31:0] rc_mask(input logic [2:0] sz, input logic [1:0] lo);
    int first, count;
    logic [31:0] m = '0;
    if (sz == 3'd0)      begin first = 8 * int'(lo);        count = 8;  end
    else if (sz == 3'd1) begin first = lo[1] ? 16 : 0;      count = 16; end
    else                 begin first = 0;                   count = 32; end
    for (int b = 0; b < 32; b++) if (b >= first && b < first + count) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] irq_exp(input logic [31:0] s, input logic [31:0] e);
    return {31'b0, |(s & e)};
  endfunction

  task automatic xfer(input string req, input bit wr, input logic [11:0] a,
                      input logic [2:0] sz, input logic [31:0] wd, input logic [31:0] ev);
    logic [31:0] clr = '0;
    logic [31:0] rd_exp = '0;
    @(negedge clk);
    hsel_i = 1'b1; htrans_i = 2'b10; haddr_i = a; hwrite_i = wr; hsize_i = sz;
    event_i = '0;
    @(negedge clk);
    hsel_i = 1'b0; htrans_i = 2'b00; hwdata_i = wd; event_i = ev;
    #1;
    if (!wr) begin
      if (a[11:2] == PRES[11:2] || a[11:2] == CLRV[11:2]) rd_exp = exp_st;
      chk(req, hrdata_o, rd_exp);
    end
    if (wr && a[11:2] == PRES[11:2]) clr = wd;
    if (!wr && a[11:2] == CLRV[11:2]) clr = rc_mask(sz, a[1:0]);
    @(negedge clk);
    event_i = '0;
    exp_st = ((exp_st & ~clr) | ev) & ~RSVD;
    #1;
    chk("R10", irq_exp(irq_o ? 32'h1 : 32'h0, 32'h1), irq_exp(exp_st, int_en_i));
  endtask

  task automatic pulse(input logic [31:0] ev);
    @(negedge clk); event_i = ev;
    @(negedge clk); event_i = '0;
    exp_st = (exp_st | ev) & ~RSVD;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", {31'b0, irq_o}, 32'h0);
    int_en_i = 32'hFFFF_FFFF;
    xfer("R1", 0, PRES, 3'd2, '0, '0);

    pulse(32'h4000_00A5);
    xfer("R2", 0, PRES, 3'd2, '0, '0);
    xfer("R4", 0, PRES, 3'd2, '0, '0);
    xfer("R3", 0, CLRV, 3'd2, '0, '0);
    xfer("R6", 0, PRES, 3'd2, '0, '0);

    pulse(32'h7FFF_FFFF);
    xfer("R5", 1, PRES, 3'd2, 32'h0F0F_0001, '0);
    xfer("R5", 0, PRES, 3'd2, '0, '0);

    for (int k = 0; k < 4; k++) begin
      pulse(32'h7FFF_FFFF);
      xfer("R6", 0, CLRV + 12'(k), 3'd0, '0, '0);
      xfer("R6", 0, PRES, 3'd2, '0, '0);
    end
    for (int k = 0; k < 2; k++) begin
      pulse(32'h7FFF_FFFF);
      xfer("R6", 0, CLRV + 12'(2 * k), 3'd1, '0, '0);
      xfer("R6", 0, PRES, 3'd2, '0, '0);
    end

    pulse(32'h0000_F00F);
    xfer("R7", 1, CLRV, 3'd2, 32'hFFFF_FFFF, '0);
    xfer("R7", 0, PRES, 3'd2, '0, '0);

    xfer("R8", 1, PRES, 3'd2, 32'hFFFF_FFFF, 32'h0000_0008);
    xfer("R8", 0, PRES, 3'd2, '0, '0);
    xfer("R8", 0, CLRV, 3'd2, '0, 32'h0001_0000);
    xfer("R8", 0, PRES, 3'd2, '0, '0);

    pulse(32'hFFFF_FFFF);
    xfer("R9", 0, PRES, 3'd2, '0, '0);

    int_en_i = 32'h0;
    xfer("R10", 0, PRES, 3'd2, '0, '0);
    int_en_i = 32'h4000_0000;
    xfer("R10", 0, PRES, 3'd2, '0, '0);
    xfer("R10", 1, PRES, 3'd2, 32'h4000_0000, '0);

    pulse(32'h0000_3C00);
    xfer("R11", 1, OTHER, 3'd2, 32'hFFFF_FFFF, '0);
    xfer("R11", 0, OTHER, 3'd2, '0, '0);
    xfer("R11", 0, PRES, 3'd2, '0, '0);

    for (int n = 0; n < 400; n++) begin
      logic [2:0]  kind = 3'($urandom_range(0, 5));
      logic [2:0]  sz   = 3'($urandom_range(0, 2));
      logic [1:0]  lo   = 2'($urandom);
      logic [31:0] ev   = ($urandom_range(0, 3) == 0) ? $urandom : 32'h0;
      logic [31:0] wd   = $urandom;
      if (sz == 3'd1) lo[0] = 1'b0;
      if (sz == 3'd2) lo = 2'b00;
      int_en_i = $urandom;
      case (kind)
        3'd0: pulse($urandom);
        3'd1: xfer("R4", 0, PRES, 3'd2, '0, ev);
        3'd2: xfer("R6", 0, CLRV + 12'(lo), sz, '0, ev);
        3'd3: xfer("R5", 1, PRES, 3'd2, wd, ev);
        3'd4: xfer("R7", 1, CLRV, 3'd2, wd, ev);
        default: xfer("R11", 0, OTHER, 3'd2, '0, ev);
      endcase
    end
    xfer("R3", 0, PRES, 3'd2, '0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule